// File: doc/BRIEF.md
# Group-Address Hash Filter

This block decides, for every received frame, whether the frame passes the receive path's group-address screen. The receive MAC gives it a start-of-frame strobe and then streams the destination address as six bytes, one per valid cycle, in wire order. While the bytes arrive, the block folds them into a 32-bit checksum one bit at a time, starting with the least-significant bit of each byte. The checksum is the reflected Ethernet CRC-32. Its six most-significant bits form an index into a 64-bit table. The table is held as four 16-bit banks. The index's upper two bits choose the bank and its lower four bits choose the bit inside that bank.

Software writes the four banks and a control word (hash enable, promiscuous) through a simple write port. Every write lands in a shadow copy. The shadow is copied into the working set only on a start-of-frame strobe, so a frame that is being hashed keeps the settings it started with. One cycle after the sixth address byte is sampled, the block raises a single-cycle `done` pulse and drives `accept` with it.

The sequencer has three states. ST_IDLE waits for the first strobe. ST_HASH consumes address bytes. ST_HOLD ignores further bytes until the next strobe. The transitions are: start strobe from any state into ST_HASH; sixth byte in ST_HASH into ST_HOLD. Any other condition keeps the current state.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset `done` and `accept` are 0, all four banks are zero, and hash enable and promiscuous are off. A group frame sent right after reset is therefore rejected.
- R2: The checksum starts at 0xFFFFFFFF when the start strobe arrives. For each data bit, the register shifts right one place, and when the data bit XOR the register's bit 0 is 1, it then XORs in 0xEDB88320. Bytes are consumed in arrival order, least-significant bit first. The 6-bit index is the final checksum shifted right by 26, with no inversion.
- R3: Index bits [5:4] select the bank and bits [3:0] select the bit inside it. Write address 0 to 3 loads bank 0 to 3 from `cfg_wdata`. Write address 4 loads the control word, where bit 0 is hash enable and bit 1 is promiscuous. Addresses 5 to 7 are ignored.
- R4: A frame is a hash candidate only when bit 0 of its first address byte is 1. When promiscuous is off, a frame with that bit 0 is rejected.
- R5: With promiscuous on, every frame is accepted whatever the table or hash enable holds.
- R6: With hash enable off and promiscuous off, group frames are rejected even when their table bit is set.
- R7: A group frame is accepted when hash enable is on and its table bit is 1. The decision appears on `accept` together with a one-cycle `done` pulse, in the cycle after the sixth byte is sampled. `accept` is 0 whenever `done` is 0.
- R8: Configuration writes reach the working set only at the next start strobe. A write made during a frame does not change that frame's decision, and it does apply to the following frame.
- R9: A start strobe during a frame discards the partial address and starts a new hash. Bytes arriving after the sixth and before the next strobe, or before any strobe at all, are ignored and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe; takes priority over a byte in the same cycle |
| rx_vld | input | 1 | Address byte valid |
| rx_byte | input | 8 | Address byte, wire order |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 to 3 banks, 4 control) |
| cfg_wdata | input | 16 | Configuration write data |
| done | output | 1 | One-cycle pulse when the decision is ready |
| accept | output | 1 | Frame passes; valid with `done` |

## Verification
Only `done` and `accept` have a latency to check. Both are registered at the clock edge that samples the sixth byte, so they are due exactly one cycle after that byte is driven, and `done` must be low again one cycle later. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. It also checks that `done` stays low after each of the first five bytes and on the cycle after the pulse. Configuration effects are checked on the frame that follows each start strobe, because that strobe is the only point where they take hold.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HASH = 2'd1,
        ST_HOLD = 2'd2
    } mhf_state_e;

    localparam logic [31:0] MHF_POLY = 32'hEDB88320;
    localparam logic [31:0] MHF_SEED = 32'hFFFFFFFF;

endpackage

// File: rtl/mhf_crc_step.sv
// Folds one data word into the reflected CRC, least-significant bit first.
module mhf_crc_step #(
    parameter int DATA_W = 8
) (
    input  logic [31:0]       crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [31:0]       crc_out
);
    import mhf_pkg::*;

    always_comb begin
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < DATA_W; b++) begin
            fb = data[b] ^ c[0];
            c  = c >> 1;
            if (fb) c = c ^ MHF_POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/mhf_cfg_regs.sv
// Shadow configuration written at any time, copied to the working set on commit.
module mhf_cfg_regs #(
    parameter int BANKS  = 4,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    input  logic                    commit,
    output logic [BANKS*WORD_W-1:0] tbl_act,
    output logic                    hash_en_act,
    output logic                    promisc_act
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BANKS);

    logic hash_en_sh, promisc_sh;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [WORD_W-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                sh_q <= wdata;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_act[g*WORD_W +: WORD_W] <= '0;
            end else if (commit) begin
                tbl_act[g*WORD_W +: WORD_W] <= sh_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hash_en_sh  <= 1'b0;
            promisc_sh  <= 1'b0;
            hash_en_act <= 1'b0;
            promisc_act <= 1'b0;
        end else begin
            if (we && addr == CTRL_ADDR) begin
                hash_en_sh <= wdata[0];
                promisc_sh <= wdata[1];
            end
            if (commit) begin
                hash_en_act <= hash_en_sh;
                promisc_act <= promisc_sh;
            end
        end
    end
endmodule

// File: rtl/mhf_bank_lookup.sv
// Upper index bits pick a bank, lower bits pick a bit in it.
module mhf_bank_lookup #(
    parameter int BANKS  = 4,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic [BANKS*WORD_W-1:0] tbl,
    input  logic [IDX_W-1:0]        idx,
    output logic                    hit
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] bank [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_split
        assign bank[g] = tbl[g*WORD_W +: WORD_W];
    end

    logic [IDX_W-BIT_W-1:0] bank_sel;
    logic [BIT_W-1:0]       bit_sel;

    assign bank_sel = idx[IDX_W-1:BIT_W];
    assign bit_sel  = idx[BIT_W-1:0];
    assign hit      = bank[bank_sel][bit_sel];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int BANKS      = 4,
    parameter int WORD_W     = 16,
    parameter int CFG_AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              done,
    output logic              accept
);
    import mhf_pkg::*;

    localparam int IDX_W = $clog2(BANKS * WORD_W);
    localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    mhf_state_e state_q, state_d;
    logic [31:0]       crc_q, crc_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              grp_q, grp_now;
    logic              take, last_byte, hit;
    logic [BANKS*WORD_W-1:0] tbl_act;
    logic              hash_en_act, promisc_act;
    logic [IDX_W-1:0]  idx;

    mhf_cfg_regs #(.BANKS(BANKS), .WORD_W(WORD_W), .ADDR_W(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .commit(rx_sof), .tbl_act(tbl_act), .hash_en_act(hash_en_act),
        .promisc_act(promisc_act)
    );

    mhf_crc_step #(.DATA_W(8)) u_crc (
        .crc_in(crc_q), .data(rx_byte), .crc_out(crc_nxt)
    );

    assign idx = crc_nxt[31 -: IDX_W];

    mhf_bank_lookup #(.BANKS(BANKS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_lut (
        .tbl(tbl_act), .idx(idx), .hit(hit)
    );

    assign take      = (state_q == ST_HASH) && rx_vld && !rx_sof;
    assign last_byte = take && (cnt_q == LAST_CNT);
    assign grp_now   = (cnt_q == '0) ? rx_byte[0] : grp_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rx_sof) state_d = ST_HASH;
            ST_HASH: if (rx_sof) state_d = ST_HASH;
                     else if (last_byte) state_d = ST_HOLD;
            ST_HOLD: if (rx_sof) state_d = ST_HASH;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and hash datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            crc_q   <= MHF_SEED;
            cnt_q   <= '0;
            grp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rx_sof) begin
                crc_q <= MHF_SEED;
                cnt_q <= '0;
                grp_q <= 1'b0;
            end else if (take) begin
                crc_q <= crc_nxt;
                cnt_q <= last_byte ? '0 : cnt_q + 1'b1;
                grp_q <= grp_now;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            accept <= 1'b0;
        end else begin
            done   <= last_byte;
            accept <= last_byte && (promisc_act || (grp_now && hash_en_act && hit));
        end
    end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int TBL_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_sof,
    input logic             rx_vld,
    input logic             done,
    input logic             accept,
    input logic [TBL_W-1:0] tbl_act,
    input logic             hash_en_act,
    input logic             promisc_act
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rx_vld) && !$past(rx_sof))); // R7
    AST_ACCEPT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> done); // R7
    AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && promisc_act) |-> accept); // R5
    AST_HASH_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !promisc_act && !hash_en_act) |-> !accept); // R6
    AST_CFG_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_sof) |-> ($stable(tbl_act) && $stable(promisc_act) && $stable(hash_en_act))); // R8
endmodule

bind mcast_hash_filter mhf_checker #(.TBL_W(BANKS*WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
    .done(done), .accept(accept), .tbl_act(tbl_act),
    .hash_en_act(hash_en_act), .promisc_act(promisc_act)
);

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_vld = 1'b0, cfg_we = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        done, accept;

    int n_chk = 0, n_bad = 0;

    // bench model of configuration
    logic [15:0] sh_w [4];
    logic        sh_hen = 0, sh_pro = 0;
    logic [15:0] ac_w [4];
    logic        ac_hen = 0, ac_pro = 0;

    always #2 clk = ~clk;

    mcast_hash_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .done(done), .accept(accept)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic t = a[8*i + b] ^ c[0];
                c = c >> 1;
                if (t) c = c ^ 32'hEDB88320;
            end
        end
        return 6'(c >> 26);
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic [5:0] x = ref_idx(a);
        logic [15:0] w = ac_w[x[5:4]];
        return ac_pro || (a[0] && ac_hen && w[x[3:0]]);
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] a, input logic [15:0] d);
        if (a < 3'd4) sh_w[a[1:0]] = d;
        else if (a == 3'd4) begin sh_hen = d[0]; sh_pro = d[1]; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
        model_write(a, d);
    endtask

    task automatic strobe();
        @(negedge clk); rx_sof = 1;
        for (int k = 0; k < 4; k++) ac_w[k] = sh_w[k];
        ac_hen = sh_hen; ac_pro = sh_pro;
        @(negedge clk); rx_sof = 0;
    endtask

    // full frame; optional write during byte 2; req names the requirement under test
    task automatic frame(input logic [47:0] a, input bit mid, input logic [2:0] ma,
                         input logic [15:0] md, input string req);
        logic exp;
        strobe();
        exp = ref_accept(a);
        for (int i = 0; i < 6; i++) begin
            rx_vld = 1; rx_byte = a[8*i +: 8];
            if (mid && i == 2) begin cfg_we = 1; cfg_addr = ma; cfg_wdata = md; end
            @(negedge clk);
            cfg_we = 0;
            if (mid && i == 2) model_write(ma, md);
            if (i < 5) check(done, 1'b0, "R7", "done early");
        end
        rx_vld = 0;
        check(done, 1'b1, "R7", "done pulse");
        check(accept, exp, req, "accept");
        @(negedge clk);
        check(done, 1'b0, "R7", "done width");
        check(accept, 1'b0, "R7", "accept idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] g;
        logic [5:0]  x;
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) begin sh_w[k] = '0; ac_w[k] = '0; end
        repeat (3) @(negedge clk);
        check(done, 1'b0, "R1", "reset done");
        check(accept, 1'b0, "R1", "reset accept");
        rst_n = 1;
        @(negedge clk);
        // bytes before any strobe are ignored (R9)
        rx_vld = 1;
        for (int i = 0; i < 7; i++) begin rx_byte = 8'h01; @(negedge clk); check(done, 1'b0, "R9", "no sof"); end
        rx_vld = 0;
        g = 48'h0000_5E00_0001; // group address, byte0=0x01
        frame(g, 0, 0, 0, "R1");
        // R2/R3: set exactly the bit the reference checksum points at
        x = ref_idx(g);
        wr({1'b0, x[5:4]}, 16'h1 << x[3:0]);
        wr(3'd4, 16'h0001);
        frame(g, 0, 0, 0, "R2");
        // R3: all other bits set; expected reject
        for (int k = 0; k < 4; k++) wr(3'(k), (k == int'(x[5:4])) ? ~(16'h1 << x[3:0]) : 16'hFFFF);
        frame(g, 0, 0, 0, "R3");
        wr(3'd5, 16'hFFFF); wr(3'd7, 16'hFFFF); // ignored addresses
        frame(g, 0, 0, 0, "R3");
        // R4: unicast with full table rejected
        for (int k = 0; k < 4; k++) wr(3'(k), 16'hFFFF);
        frame(48'h1234_5678_9A02, 0, 0, 0, "R4");
        frame(g, 0, 0, 0, "R7");
        // R6: hash disabled
        wr(3'd4, 16'h0000);
        frame(g, 0, 0, 0, "R6");
        // R5: promiscuous, empty table
        for (int k = 0; k < 4; k++) wr(3'(k), 16'h0000);
        wr(3'd4, 16'h0002);
        frame(48'h1234_5678_9A02, 0, 0, 0, "R5");
        frame(g, 0, 0, 0, "R5");
        // R8: mid-frame control change does not apply now, does next frame
        frame(g, 1, 3'd4, 16'h0000, "R8");
        frame(g, 0, 0, 0, "R8");
        // R9: restart mid-frame, then excess bytes ignored
        strobe();
        rx_vld = 1;
        for (int i = 0; i < 3; i++) begin rx_byte = 8'hFF; @(negedge clk); end
        rx_vld = 0;
        for (int k = 0; k < 4; k++) wr(3'(k), 16'h1 << x[3:0]);
        wr(3'd4, 16'h0001);
        frame(g, 0, 0, 0, "R9");
        rx_vld = 1;
        for (int i = 0; i < 8; i++) begin rx_byte = 8'h01; @(negedge clk); check(done, 1'b0, "R9", "extra bytes"); end
        rx_vld = 0;
        // randomised frames
        for (int n = 0; n < 80; n++) begin
            logic [47:0] a;
            if ($urandom_range(0, 3) == 0)
                for (int k = 0; k < 4; k++) wr(3'(k), 16'($urandom));
            if ($urandom_range(0, 4) == 0)
                wr(3'd4, 16'($urandom_range(0, 3)));
            a = {16'($urandom), 32'($urandom)};
            a[0] = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 5) == 0)
                frame(a, 1, 3'($urandom_range(0, 4)), 16'($urandom), "R8");
            else
                frame(a, 0, 0, 0, "R7");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule